// File: doc/BRIEF.md
# Block-Striped Parity Array Controller

This controller sits between a single host block port and a set of NDATA+1 word-wide storage ports. Logical blocks are spread across the NDATA data positions of each stripe, and each stripe keeps one parity block that is the XOR of its data blocks. A host read touches only the disk that holds the block. A host write updates that one block and its parity by a read-modify-write: the old data and the old parity are read, then the new data and the new parity are written. When one disk is flagged as failed, a read of a block held on that disk is rebuilt by XOR of the same stripe on every surviving disk.

The host hands over one request at a time with a valid/ready handshake. The request carries a whole block, and each operation ends with a one-cycle done pulse and an error flag. Behind the controller, blocks move one word per storage access. Each access is a request held on one port until that port acknowledges it. A mode input chooses where parity lives: on the last disk for every stripe, or on a disk that rotates from stripe to stripe.

Top module: `raid_parity_ctl`

## Requirements
- R1: Logical block L sits in stripe L/NDATA at position L mod NDATA. Disks are numbered 0 to NDATA. In fixed mode (`dist_mode`=0) parity for every stripe is on disk NDATA and position j is on disk j. Word w of a block sits at storage address stripe*BLK_WORDS+w.
- R2: In rotating mode (`dist_mode`=1) the parity disk of stripe s is NDATA-(s mod (NDATA+1)). The data positions fill the other disks in ascending order.
- R3: A read whose target disk is not failed makes exactly BLK_WORDS read accesses, to the target disk only, at word addresses in ascending order. It returns that block on `h_rblk` (word w in bits [w*WORD_W +: WORD_W]) with `h_err`=0. At most one storage request is raised at any time.
- R4: A write makes exactly 4*BLK_WORDS accesses in this order: read the old data block, read the old parity block, write the new data block, write the new parity block. A request's address, write flag and port stay fixed until that port acknowledges.
- R5: After a write, the data disk holds the new block and the parity disk holds old parity XOR old data XOR new data, word by word. The operation reports `h_err`=0.
- R6: With exactly one disk failed, a read of a block held on the failed disk returns the XOR of that stripe's blocks on all other disks, parity included. It reads those disks in ascending disk order, one whole block per disk.
- R7: A write whose data disk or parity disk is failed completes with `h_err`=1 and makes no storage access.
- R8: Any request made while two or more bits of `fail_mask` are set completes with `h_err`=1 on the cycle after acceptance and makes no storage access.
- R9: `h_ready` is high only while no operation is in progress, and no storage request is raised while it is high. Each accepted request yields exactly one `h_done` pulse one cycle wide, after which `h_ready` is high again.
- R10: While and after reset, `h_ready`=1, `h_done`=0 and no storage request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dist_mode | input | 1 | 0: parity on disk NDATA; 1: parity rotates per stripe |
| fail_mask | input | NDATA+1 | One bit per disk, 1 = disk failed |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Controller can accept a request |
| h_write | input | 1 | 1 = write, 0 = read |
| h_lba | input | LBA_W | Logical block number |
| h_wblk | input | WORD_W*BLK_WORDS | Block to write |
| h_done | output | 1 | One-cycle completion pulse |
| h_err | output | 1 | Error flag, valid with h_done |
| h_rblk | output | WORD_W*BLK_WORDS | Block read, valid with h_done |
| st_req | output | NDATA+1 | Per-disk access request |
| st_we | output | 1 | Access is a write |
| st_addr | output | LBA_W+log2(BLK_WORDS) | Word address on the disk |
| st_wdata | output | WORD_W | Word to write |
| st_ack | input | NDATA+1 | Per-disk acknowledge, read data valid with it |
| st_rdata | input | (NDATA+1)*WORD_W | Per-disk read word |

## Verification
A wrong stripe, disk or word counter shows at once, on the next storage request, as a wrong port or address. The bench logs every acknowledged access and compares the whole trace with the one the requirements imply. A corrupted XOR buffer is not visible in the write trace itself. It shows as a wrong parity word in the bench's storage right after the write, and again later as a wrong rebuilt block when that stripe is read in degraded mode. A wrong error decision shows within one request as either an unexpected `h_err` or storage traffic where none should occur.

// File: rtl/raid_pkg.sv
// Shared types for the parity array controller.
// Assumes: one operation in flight at a time.
package raid_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DATA,
        ST_RD_PAR,
        ST_WR_DATA,
        ST_WR_PAR,
        ST_SCAN,
        ST_DONE
    } ctl_state_e;

endpackage

// File: rtl/raid_map.sv
// Block-to-disk mapper: turns a logical block number into a stripe index,
// the disk that holds the block and the disk that holds the stripe parity.
// Assumes: LBA_W is wide enough to hold NDATA+1; purely combinational.
module raid_map #(
    parameter int NDATA  = 4,
    parameter int LBA_W  = 6,
    parameter int DISK_W = 3
) (
    input  logic [LBA_W-1:0]  lba,
    input  logic              dist_mode,
    output logic [LBA_W-1:0]  stripe,
    output logic [DISK_W-1:0] data_disk,
    output logic [DISK_W-1:0] par_disk
);
    localparam int NDISK = NDATA + 1;

    logic [LBA_W-1:0]  pos_full;
    logic [LBA_W-1:0]  rot_full;
    logic [DISK_W-1:0] pos;

    // Split the block number into stripe and position, then place parity.
    always_comb begin
        stripe   = lba / LBA_W'(NDATA);
        pos_full = lba % LBA_W'(NDATA);
        rot_full = stripe % LBA_W'(NDISK);
        pos      = DISK_W'(pos_full);
        if (dist_mode)
            par_disk = DISK_W'(NDATA) - DISK_W'(rot_full);
        else
            par_disk = DISK_W'(NDATA);
        data_disk = (pos < par_disk) ? pos : pos + DISK_W'(1);
    end

endmodule

// File: rtl/raid_blkbuf.sv
// One-block word buffer with XOR accumulation.
// Assumes: clear has priority over accumulation; one word touched per cycle.
module raid_blkbuf #(
    parameter int WORD_W    = 8,
    parameter int BLK_WORDS = 4,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        xor_en,
    input  logic [IDX_W-1:0]            idx,
    input  logic [WORD_W-1:0]           din,
    output logic [WORD_W-1:0]           word_out,
    output logic [WORD_W*BLK_WORDS-1:0] blk_out
);
    genvar gi;
    generate
        for (gi = 0; gi < BLK_WORDS; gi++) begin : g_word
            logic [WORD_W-1:0] q;
            // Hold one word: clear on a new operation, XOR in a read word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (clr)
                    q <= '0;
                else if (xor_en && (idx == IDX_W'(gi)))
                    q <= q ^ din;
            end
            assign blk_out[gi*WORD_W +: WORD_W] = q;
        end
    endgenerate

    // Select the word at the current index.
    always_comb word_out = blk_out[idx*WORD_W +: WORD_W];

endmodule

// File: rtl/raid_port_sel.sv
// Storage port selector: raises the request of the current disk and
// returns that disk's acknowledge and read word.
// Assumes: at most one disk addressed at a time.
module raid_port_sel #(
    parameter int NDISK  = 5,
    parameter int WORD_W = 8,
    parameter int DISK_W = 3
) (
    input  logic                    active,
    input  logic [DISK_W-1:0]       cur,
    output logic [NDISK-1:0]        req,
    input  logic [NDISK-1:0]        ack,
    input  logic [NDISK*WORD_W-1:0] rdata,
    output logic                    ack_sel,
    output logic [WORD_W-1:0]       rdata_sel
);
    genvar gk;
    generate
        for (gk = 0; gk < NDISK; gk++) begin : g_req
            assign req[gk] = active && (cur == DISK_W'(gk));
        end
    endgenerate

    // Pick the acknowledge and word of the addressed disk.
    always_comb begin
        ack_sel   = 1'b0;
        rdata_sel = '0;
        for (int k = 0; k < NDISK; k++) begin
            if (cur == DISK_W'(k)) begin
                ack_sel   = ack[k];
                rdata_sel = rdata[k*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/raid_parity_ctl.sv
// Parity array controller top: accepts one host block request at a time,
// runs plain reads, four-pass read-modify-write updates and degraded
// rebuild reads over NDATA+1 word-serial storage ports.
// Assumes: storage ports hold read data valid with ack; fail_mask and
// dist_mode are sampled when a request is accepted.
module raid_parity_ctl #(
    parameter int NDATA     = 4,
    parameter int WORD_W    = 8,
    parameter int BLK_WORDS = 4,
    parameter int LBA_W     = 6,
    localparam int NDISK     = NDATA + 1,
    localparam int BLK_W     = WORD_W * BLK_WORDS,
    localparam int IDX_W     = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1,
    localparam int ST_ADDR_W = LBA_W + IDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dist_mode,
    input  logic [NDISK-1:0]        fail_mask,
    input  logic                    h_valid,
    output logic                    h_ready,
    input  logic                    h_write,
    input  logic [LBA_W-1:0]        h_lba,
    input  logic [BLK_W-1:0]        h_wblk,
    output logic                    h_done,
    output logic                    h_err,
    output logic [BLK_W-1:0]        h_rblk,
    output logic [NDISK-1:0]        st_req,
    output logic                    st_we,
    output logic [ST_ADDR_W-1:0]    st_addr,
    output logic [WORD_W-1:0]       st_wdata,
    input  logic [NDISK-1:0]        st_ack,
    input  logic [NDISK*WORD_W-1:0] st_rdata
);
    import raid_pkg::*;

    localparam int DISK_W = $clog2(NDATA + 3);
    localparam logic [IDX_W-1:0] LAST_W = IDX_W'(BLK_WORDS - 1);

    ctl_state_e         state_q;
    logic [DISK_W-1:0]  cur_q;
    logic [IDX_W-1:0]   widx_q;
    logic [LBA_W-1:0]   stripe_q;
    logic [DISK_W-1:0]  dd_q;
    logic [DISK_W-1:0]  pd_q;
    logic               wr_q;
    logic               err_q;
    logic [BLK_W-1:0]   wblk_q;

    logic [LBA_W-1:0]   m_stripe;
    logic [DISK_W-1:0]  m_dd;
    logic [DISK_W-1:0]  m_pd;
    logic               accept;
    logic               multi_fail;
    logic               reject;
    logic               active;
    logic               reading;
    logic               ack_sel;
    logic [WORD_W-1:0]  rdata_sel;
    logic [WORD_W-1:0]  buf_word;
    logic [WORD_W-1:0]  new_word;
    logic               word_end;
    logic [DISK_W-1:0]  scan_nxt;
    logic [DISK_W-1:0]  scan_first;

    raid_map #(
        .NDATA (NDATA),
        .LBA_W (LBA_W),
        .DISK_W(DISK_W)
    ) map_i (
        .lba      (h_lba),
        .dist_mode(dist_mode),
        .stripe   (m_stripe),
        .data_disk(m_dd),
        .par_disk (m_pd)
    );

    raid_port_sel #(
        .NDISK (NDISK),
        .WORD_W(WORD_W),
        .DISK_W(DISK_W)
    ) port_i (
        .active   (active),
        .cur      (cur_q),
        .req      (st_req),
        .ack      (st_ack),
        .rdata    (st_rdata),
        .ack_sel  (ack_sel),
        .rdata_sel(rdata_sel)
    );

    raid_blkbuf #(
        .WORD_W   (WORD_W),
        .BLK_WORDS(BLK_WORDS),
        .IDX_W    (IDX_W)
    ) buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .xor_en  (reading && ack_sel),
        .idx     (widx_q),
        .din     (rdata_sel),
        .word_out(buf_word),
        .blk_out (h_rblk)
    );

    // Decode the accepted request: failure count and reject decision.
    always_comb begin
        int nfail;
        nfail = 0;
        for (int k = 0; k < NDISK; k++)
            if (fail_mask[k]) nfail++;
        multi_fail = (nfail > 1);
        accept     = h_valid && (state_q == ST_IDLE);
        reject     = multi_fail || (h_write && (fail_mask[m_dd] || fail_mask[m_pd]));
        scan_first = (m_dd == '0) ? DISK_W'(1) : '0;
    end

    // Classify the current state and form the storage command.
    always_comb begin
        active   = (state_q == ST_RD_DATA) || (state_q == ST_RD_PAR) ||
                   (state_q == ST_WR_DATA) || (state_q == ST_WR_PAR) ||
                   (state_q == ST_SCAN);
        reading  = (state_q == ST_RD_DATA) || (state_q == ST_RD_PAR) ||
                   (state_q == ST_SCAN);
        st_we    = (state_q == ST_WR_DATA) || (state_q == ST_WR_PAR);
        st_addr  = {stripe_q, widx_q};
        new_word = wblk_q[widx_q*WORD_W +: WORD_W];
        st_wdata = (state_q == ST_WR_PAR) ? (buf_word ^ new_word) : new_word;
        word_end = active && ack_sel && (widx_q == LAST_W);
        scan_nxt = cur_q + DISK_W'(1);
        if (scan_nxt == dd_q)
            scan_nxt = cur_q + DISK_W'(2);
    end

    // Host-side status outputs.
    always_comb begin
        h_ready = (state_q == ST_IDLE);
        h_done  = (state_q == ST_DONE);
        h_err   = (state_q == ST_DONE) && err_q;
    end

    // Operation sequencer: request capture, word stepping, pass ordering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cur_q    <= '0;
            widx_q   <= '0;
            stripe_q <= '0;
            dd_q     <= '0;
            pd_q     <= '0;
            wr_q     <= 1'b0;
            err_q    <= 1'b0;
            wblk_q   <= '0;
        end else begin
            if (active && ack_sel)
                widx_q <= (widx_q == LAST_W) ? '0 : widx_q + IDX_W'(1);
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        stripe_q <= m_stripe;
                        dd_q     <= m_dd;
                        pd_q     <= m_pd;
                        wr_q     <= h_write;
                        wblk_q   <= h_wblk;
                        widx_q   <= '0;
                        err_q    <= reject;
                        if (reject) begin
                            state_q <= ST_DONE;
                        end else if (!h_write && fail_mask[m_dd]) begin
                            state_q <= ST_SCAN;
                            cur_q   <= scan_first;
                        end else begin
                            state_q <= ST_RD_DATA;
                            cur_q   <= m_dd;
                        end
                    end
                end
                ST_RD_DATA: begin
                    if (word_end) begin
                        if (wr_q) begin
                            state_q <= ST_RD_PAR;
                            cur_q   <= pd_q;
                        end else begin
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_RD_PAR: begin
                    if (word_end) begin
                        state_q <= ST_WR_DATA;
                        cur_q   <= dd_q;
                    end
                end
                ST_WR_DATA: begin
                    if (word_end) begin
                        state_q <= ST_WR_PAR;
                        cur_q   <= pd_q;
                    end
                end
                ST_WR_PAR: begin
                    if (word_end)
                        state_q <= ST_DONE;
                end
                ST_SCAN: begin
                    if (word_end) begin
                        if (scan_nxt > DISK_W'(NDATA))
                            state_q <= ST_DONE;
                        else
                            cur_q <= scan_nxt;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/raid_parity_ctl_chk.sv
// Port-level property checker for the parity array controller.
// Assumes: attached by bind; observes ports only.
module raid_parity_ctl_chk #(
    parameter int NDISK  = 5,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              h_valid,
    input logic              h_ready,
    input logic              h_done,
    input logic              h_err,
    input logic [NDISK-1:0]  fail_mask,
    input logic [NDISK-1:0]  st_req,
    input logic [NDISK-1:0]  st_ack,
    input logic              st_we,
    input logic [ADDR_W-1:0] st_addr
);
    AST_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(st_req)); // R3
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n) (|(st_req & ~st_ack)) |=> ($stable(st_req) && $stable(st_addr) && $stable(st_we))); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) h_done |=> !h_done); // R9
    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) h_ready |-> (st_req == '0)); // R9
    AST_MULTI_FAIL_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (h_valid && h_ready && ($countones(fail_mask) > 1)) |=> (h_done && h_err && (st_req == '0))); // R8
endmodule

bind raid_parity_ctl raid_parity_ctl_chk #(
    .NDISK (NDATA + 1),
    .ADDR_W(ST_ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_valid  (h_valid),
    .h_ready  (h_ready),
    .h_done   (h_done),
    .h_err    (h_err),
    .fail_mask(fail_mask),
    .st_req   (st_req),
    .st_ack   (st_ack),
    .st_we    (st_we),
    .st_addr  (st_addr)
);

// File: tb/raid_parity_ctl_tb.sv
// Bench for the parity array controller: behavioural storage, a block
// model of the array and an access trace compared per operation.
module raid_parity_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 4;
    localparam int NK = ND + 1;
    localparam int BW = 4;
    localparam int NLBA = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dist_mode = 1'b0;
    logic [4:0]  fail_mask = '0;
    logic        h_valid = 1'b0;
    logic        h_ready;
    logic        h_write = 1'b0;
    logic [5:0]  h_lba = '0;
    logic [31:0] h_wblk = '0;
    logic        h_done;
    logic        h_err;
    logic [31:0] h_rblk;
    logic [4:0]  st_req;
    logic        st_we;
    logic [7:0]  st_addr;
    logic [7:0]  st_wdata;
    logic [4:0]  st_ack = '0;
    logic [39:0] st_rdata = '0;

    logic [7:0] mem  [NK][256];
    logic [7:0] gold [NLBA][BW];
    int acc_q[$];
    int n_checks = 0;
    int n_fail = 0;

    raid_parity_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .dist_mode(dist_mode), .fail_mask(fail_mask),
        .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write), .h_lba(h_lba),
        .h_wblk(h_wblk), .h_done(h_done), .h_err(h_err), .h_rblk(h_rblk),
        .st_req(st_req), .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata),
        .st_ack(st_ack), .st_rdata(st_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Storage responder: acknowledge one cycle after a new request, log it.
    always @(negedge clk) begin
        for (int k = 0; k < NK; k++) begin
            if (st_req[k] && !st_ack[k]) begin
                if (st_we) mem[k][st_addr] = st_wdata;
                st_rdata[k*8 +: 8] = mem[k][st_addr];
                st_ack[k] = 1'b1;
                acc_q.push_back(k*1024 + (st_we ? 512 : 0) + int'(st_addr));
            end else begin
                st_ack[k] = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int par_of(input int s, input bit dm);
        return dm ? ND - (s % NK) : ND;
    endfunction

    function automatic int disk_of(input int lba, input bit dm);
        int p = par_of(lba / ND, dm);
        int j = lba % ND;
        return (j < p) ? j : j + 1;
    endfunction

    // Load the array with a pattern and consistent parity for a mode.
    task automatic load_array(input bit dm, input int seed);
        for (int s = 0; s < NLBA/ND; s++) begin
            for (int w = 0; w < BW; w++) begin
                logic [7:0] px = '0;
                for (int j = 0; j < ND; j++) begin
                    int l = s*ND + j;
                    gold[l][w] = 8'(l*37 + w*11 + seed*13 + 5);
                    mem[disk_of(l, dm)][s*BW + w] = gold[l][w];
                    px ^= gold[l][w];
                end
                mem[par_of(s, dm)][s*BW + w] = px;
            end
        end
    endtask

    // Run one host request and compare its result and access trace.
    task automatic run_op(input bit wr, input int lba, input logic [31:0] blk, input string req);
        int s = lba / ND;
        int p = par_of(s, dist_mode);
        int d = disk_of(lba, dist_mode);
        bit exp_err;
        int exp_q[$];
        logic [31:0] exp_blk;
        logic [31:0] got_blk;
        bit got_err;
        int n = 0;
        exp_err = ($countones(fail_mask) > 1) || (wr && (fail_mask[d] || fail_mask[p]));
        for (int w = 0; w < BW; w++) exp_blk[w*8 +: 8] = gold[lba][w];
        if (!exp_err) begin
            if (wr) begin
                for (int w = 0; w < BW; w++) exp_q.push_back(d*1024 + s*BW + w);
                for (int w = 0; w < BW; w++) exp_q.push_back(p*1024 + s*BW + w);
                for (int w = 0; w < BW; w++) exp_q.push_back(d*1024 + 512 + s*BW + w);
                for (int w = 0; w < BW; w++) exp_q.push_back(p*1024 + 512 + s*BW + w);
            end else if (fail_mask[d]) begin
                for (int k = 0; k < NK; k++)
                    if (k != d)
                        for (int w = 0; w < BW; w++) exp_q.push_back(k*1024 + s*BW + w);
            end else begin
                for (int w = 0; w < BW; w++) exp_q.push_back(d*1024 + s*BW + w);
            end
        end
        acc_q.delete();
        @(negedge clk);
        h_valid = 1'b1; h_write = wr; h_lba = 6'(lba); h_wblk = blk;
        while (!h_ready) @(negedge clk);
        @(negedge clk);
        h_valid = 1'b0;
        while (!h_done && n < 2000) begin @(negedge clk); n++; end
        check(h_done, req, "done never seen", 0, 1);
        got_err = h_err;
        got_blk = h_rblk;
        check(got_err == exp_err, req, "error flag", 64'(got_err), 64'(exp_err));
        if (!exp_err && !wr)
            check(got_blk == exp_blk, req, "read block", 64'(got_blk), 64'(exp_blk));
        @(negedge clk);
        check(!h_done && h_ready, "R9", "done pulse width / ready", {h_done, h_ready}, 2'b01);
        check(acc_q.size() == exp_q.size(), req, "access count", 64'(acc_q.size()), 64'(exp_q.size()));
        if (acc_q.size() == exp_q.size())
            for (int i = 0; i < exp_q.size(); i++)
                if (acc_q[i] != exp_q[i]) begin
                    check(0, req, "access trace entry", 64'(acc_q[i]), 64'(exp_q[i]));
                    break;
                end
        if (wr && !exp_err) begin
            bit ok = 1;
            logic [7:0] px;
            for (int w = 0; w < BW; w++) gold[lba][w] = blk[w*8 +: 8];
            for (int w = 0; w < BW; w++) begin
                px = '0;
                for (int j = 0; j < ND; j++) px ^= gold[s*ND + j][w];
                if (mem[d][s*BW + w] != gold[lba][w] || mem[p][s*BW + w] != px) ok = 0;
            end
            check(ok, "R5", "stored data/parity after write", 64'(mem[p][s*BW]), 64'(px));
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        load_array(1'b0, 1);
        repeat (3) @(negedge clk);
        check(h_ready == 1'b1, "R10", "ready in reset", 64'(h_ready), 1);
        check(h_done == 1'b0, "R10", "done in reset", 64'(h_done), 0);
        check(st_req == '0, "R10", "storage request in reset", 64'(st_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(h_ready && !h_done && st_req == '0, "R10", "state after reset", {h_ready, h_done, st_req}, 7'b1000000);

        // Fixed parity placement: plain reads and a write (R1, R3, R4, R5).
        run_op(0, 0, '0, "R1");
        run_op(0, 5, '0, "R3");
        run_op(0, 63, '0, "R1");
        run_op(1, 6, 32'hA5C3_0F71, "R4");
        run_op(0, 6, '0, "R3");

        // One failed data disk: rebuild reads and writes (R6, R7).
        fail_mask = 5'b00100;
        run_op(0, 2, '0, "R6");
        run_op(0, 6, '0, "R6");
        run_op(1, 10, 32'h1122_3344, "R7");
        run_op(1, 9, 32'hDEAD_BEEF, "R5");
        run_op(0, 10, '0, "R6");

        // Failed parity disk: reads still plain, writes rejected (R3, R7).
        fail_mask = 5'b10000;
        run_op(0, 1, '0, "R3");
        run_op(1, 1, 32'h5555_AAAA, "R7");

        // Two failed disks: every request rejected (R8).
        fail_mask = 5'b00011;
        run_op(0, 0, '0, "R8");
        run_op(1, 7, 32'h0102_0304, "R8");

        // Rotating parity placement (R2, R5, R6).
        fail_mask = '0;
        dist_mode = 1'b1;
        load_array(1'b1, 2);
        run_op(0, 4, '0, "R2");
        run_op(0, 7, '0, "R2");
        run_op(1, 13, 32'h8899_CCDD, "R2");
        run_op(0, 13, '0, "R2");
        fail_mask = 5'b00001;
        run_op(0, 16, '0, "R2");
        run_op(0, 20, '0, "R6");
        fail_mask = 5'b00100;
        run_op(0, 13, '0, "R6");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule